// File: doc/BRIEF.md
# Card Information Tuple Stream Parser

This block takes card information data as a byte stream, one byte on each cycle where `in_valid` is high. It follows the chain of type/length/value tuples. Each tuple is a type byte, then a length byte, then exactly that many payload bytes; the length does not count the type and length bytes. From the tuples it recognises, the block pulls configuration fields into output registers. Each field has its own valid flag.

Two tuple kinds are decoded. The function-extension tuple (type 0x22) carries the 6-byte LAN node ID, which is the MAC address. The vendor tuple (type 0x80) carries one subelement. The first payload byte of that tuple names the subelement, and the remaining payload bytes are its data. From the vendor tuple the block extracts power-amplifier coefficients, the country code, the antenna bitmap, the low 16 bits of the board flags, and the LED information. A subelement that has the wrong size raises a sticky error flag and leaves its field untouched. A terminator type byte stops the parse.

A host pulses `start` before it streams a new structure. The byte source, CRC checking and any bus interface sit outside this block.

Top module: `cis_tuple_parser`

## Requirements
- R1: The parser walks tuples in this form: type byte, length byte, then `length` payload bytes. Tuples with other type codes, and tuples of length zero, are skipped. The byte after a tuple's last payload byte is read as the next type byte.
- R2: A type byte of 0xFF sets `done`. While `done` is high, all input bytes are ignored and no field, valid flag or error changes. Only `start` or reset clears `done`.
- R3: Type 0x22 with payload `04 06 n0 n1 n2 n3 n4 n5` (tuple length 8) loads `mac_addr = {n0,n1,n2,n3,n4,n5}`, with n0 in bits 47:40, and sets `mac_vld`. A 0x22 tuple whose first payload byte is 0x04 but whose tuple length is not 8, or whose second payload byte is not 0x06, sets `err`.
- R4: Type 0x80 with subelement 0x03 and 8 data bytes d0..d7 loads `pa_b0={d1,d0}`, `pa_b1={d3,d2}`, `pa_b2={d5,d4}`, `pa_tssi=d6` and `pa_maxpwr=d7`, and sets `pa_vld`.
- R5: Vendor subelement 0x05 with 1 data byte loads `country` and sets `country_vld`. Subelement 0x06 with 1 data byte loads `antennas` and sets `ant_vld`.
- R6: Vendor subelement 0x08 with 2 data bytes loads `board_flags = {d1,d0}` and sets `bflags_vld`. Subelement 0x09 with 4 data bytes loads `led_info = {d3,d2,d1,d0}` and sets `led_vld`.
- R7: For subelements 0x03, 0x05, 0x06, 0x08 and 0x09, a data size (tuple length minus 1) that differs from the expected size sets `err` and leaves that field and its valid flag unchanged. A vendor tuple of length 0 also sets `err`. Other subelement codes are skipped without an error.
- R8: Valid flags and `err` are sticky. A `start` pulse clears them, clears `done`, clears all fields, and drops any tuple in progress. A byte presented in the same cycle as `start` is dropped.
- R9: A cycle with `in_valid` low changes nothing, whatever the value of `in_byte`.
- R10: After reset, `done`, `err` and every valid flag are 0, and every field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear results and restart the parse |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| done | output | 1 | Terminator seen |
| err | output | 1 | Sticky malformed-subelement flag |
| mac_addr | output | 48 | LAN node ID, first byte in the top bits |
| mac_vld | output | 1 | `mac_addr` loaded |
| pa_b0 | output | 16 | PA coefficient 0 |
| pa_b1 | output | 16 | PA coefficient 1 |
| pa_b2 | output | 16 | PA coefficient 2 |
| pa_tssi | output | 8 | Idle TSSI target |
| pa_maxpwr | output | 8 | Maximum PA power |
| pa_vld | output | 1 | PA fields loaded |
| country | output | 8 | Country code |
| country_vld | output | 1 | `country` loaded |
| antennas | output | 8 | Antenna bitmap |
| ant_vld | output | 1 | `antennas` loaded |
| board_flags | output | 16 | Board flags, low half |
| bflags_vld | output | 1 | `board_flags` loaded |
| led_info | output | 32 | LED information |
| led_vld | output | 1 | `led_info` loaded |

## Verification
Each subelement kind is streamed on its own, with distinct byte values at every position. A byte-order or offset slip therefore shows up as a wrong field value. Other streams check the tuple walk itself. An unknown tuple, or a zero-length tuple, placed ahead of a good one shows whether payload counting lands on the right next type byte. A terminator placed before a good tuple separates "stopped" from "kept parsing". Wrong-size subelements, a malformed node ID, an ignored subelement code, idle cycles carrying 0xFF, and a restart in the middle of a tuple each probe a different path: error versus update versus silent skip.

// File: rtl/cis_pkg.sv
package cis_pkg;
    localparam logic [7:0] TUP_TERM    = 8'hFF;
    localparam logic [7:0] TUP_FUNCEXT = 8'h22;
    localparam logic [7:0] TUP_VENDOR  = 8'h80;
    localparam logic [7:0] FX_NODE_ID  = 8'h04;
    localparam logic [7:0] NODE_ID_LEN = 8'h06;

    localparam logic [7:0] SUB_PA      = 8'h03;
    localparam logic [7:0] SUB_COUNTRY = 8'h05;
    localparam logic [7:0] SUB_ANT     = 8'h06;
    localparam logic [7:0] SUB_BFLAGS  = 8'h08;
    localparam logic [7:0] SUB_LED     = 8'h09;

    typedef enum logic [1:0] {
        W_TYPE = 2'd0,
        W_LEN  = 2'd1,
        W_BODY = 2'd2,
        W_DONE = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic [47:0] mac;
        logic        mac_vld;
        logic [15:0] pa_b0;
        logic [15:0] pa_b1;
        logic [15:0] pa_b2;
        logic [7:0]  pa_tssi;
        logic [7:0]  pa_maxpwr;
        logic        pa_vld;
        logic [7:0]  country;
        logic        country_vld;
        logic [7:0]  antennas;
        logic        ant_vld;
        logic [15:0] bflags;
        logic        bflags_vld;
        logic [31:0] led;
        logic        led_vld;
        logic        err;
    } field_set_t;
endpackage

// File: rtl/cis_tuple_walker.sv
module cis_tuple_walker
    import cis_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             pl_valid,
    output logic [LEN_W-1:0] pl_idx,
    output logic             tup_end,
    output logic [7:0]       end_type,
    output logic [LEN_W-1:0] end_len,
    output logic             done
);
    typedef struct packed {
        walk_state_e      st;
        logic [7:0]       ttype;
        logic [LEN_W-1:0] tlen;
        logic [LEN_W-1:0] idx;
    } walk_t;

    localparam walk_t WALK_RST = '{st: W_TYPE, ttype: 8'h00, tlen: '0, idx: '0};

    walk_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        pl_valid = 1'b0;
        tup_end  = 1'b0;
        pl_idx   = w_q.idx;
        end_type = w_q.ttype;
        end_len  = w_q.tlen;
        if (start) begin
            w_d = WALK_RST;
        end else if (in_valid) begin
            unique case (w_q.st)
                W_TYPE: begin
                    if (in_byte == TUP_TERM) begin
                        w_d.st = W_DONE;
                    end else begin
                        w_d.ttype = in_byte;
                        w_d.st    = W_LEN;
                    end
                end
                W_LEN: begin
                    w_d.tlen = LEN_W'(in_byte);
                    w_d.idx  = '0;
                    if (in_byte == 8'h00) begin
                        tup_end = 1'b1;
                        end_len = '0;
                        w_d.st  = W_TYPE;
                    end else begin
                        w_d.st = W_BODY;
                    end
                end
                W_BODY: begin
                    pl_valid = 1'b1;
                    w_d.idx  = w_q.idx + 1'b1;
                    if (w_q.idx == w_q.tlen - 1'b1) begin
                        tup_end = 1'b1;
                        w_d.st  = W_TYPE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= WALK_RST;
        else        w_q <= w_d;
    end

    assign done = (w_q.st == W_DONE);

    AST_IDX_IN_TUPLE: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> (pl_idx < w_q.tlen)); // R1
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R2
    AST_DONE_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!pl_valid && !tup_end)); // R2
endmodule

// File: rtl/cis_payload_buf.sv
module cis_payload_buf #(
    parameter int NBYTES = 9,
    parameter int LEN_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pl_valid,
    input  logic [LEN_W-1:0]       pl_idx,
    input  logic [7:0]             pl_byte,
    output logic [NBYTES-1:0][7:0] view
);
    logic [NBYTES-1:0][7:0] buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        for (int i = 0; i < NBYTES; i++) begin
            if (pl_valid && pl_idx == LEN_W'(i)) buf_d[i] = pl_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    // The byte arriving now is merged so a tuple can be committed on its last byte.
    for (genvar g = 0; g < NBYTES; g++) begin : g_view
        assign view[g] = (pl_valid && pl_idx == LEN_W'(g)) ? pl_byte : buf_q[g];
    end
endmodule

// File: rtl/cis_field_regs.sv
module cis_field_regs
    import cis_pkg::*;
#(
    parameter int NBYTES = 9,
    parameter int LEN_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   tup_end,
    input  logic [7:0]             end_type,
    input  logic [LEN_W-1:0]       end_len,
    input  logic [NBYTES-1:0][7:0] view,
    output field_set_t             fields
);
    localparam logic [LEN_W-1:0] FX_TUP_LEN = LEN_W'(8);

    field_set_t f_d, f_q;
    logic [7:0]       sub;
    logic [LEN_W-1:0] dsize;
    logic             size_ok;

    function automatic logic [LEN_W-1:0] sub_size(input logic [7:0] code);
        unique case (code)
            SUB_PA:      sub_size = LEN_W'(8);
            SUB_COUNTRY: sub_size = LEN_W'(1);
            SUB_ANT:     sub_size = LEN_W'(1);
            SUB_BFLAGS:  sub_size = LEN_W'(2);
            SUB_LED:     sub_size = LEN_W'(4);
            default:     sub_size = '0;
        endcase
    endfunction

    always_comb begin
        f_d     = f_q;
        sub     = view[0];
        dsize   = end_len - 1'b1;
        size_ok = (dsize == sub_size(sub));
        if (start) begin
            f_d = '0;
        end else if (tup_end) begin
            if (end_type == TUP_FUNCEXT && end_len != '0 && view[0] == FX_NODE_ID) begin
                if (end_len == FX_TUP_LEN && view[1] == NODE_ID_LEN) begin
                    f_d.mac     = {view[2], view[3], view[4], view[5], view[6], view[7]};
                    f_d.mac_vld = 1'b1;
                end else begin
                    f_d.err = 1'b1;
                end
            end else if (end_type == TUP_VENDOR) begin
                if (end_len == '0) begin
                    f_d.err = 1'b1;
                end else if (sub_size(sub) != '0) begin
                    if (!size_ok) begin
                        f_d.err = 1'b1;
                    end else begin
                        unique case (sub)
                            SUB_PA: begin
                                f_d.pa_b0     = {view[2], view[1]};
                                f_d.pa_b1     = {view[4], view[3]};
                                f_d.pa_b2     = {view[6], view[5]};
                                f_d.pa_tssi   = view[7];
                                f_d.pa_maxpwr = view[8];
                                f_d.pa_vld    = 1'b1;
                            end
                            SUB_COUNTRY: begin
                                f_d.country     = view[1];
                                f_d.country_vld = 1'b1;
                            end
                            SUB_ANT: begin
                                f_d.antennas = view[1];
                                f_d.ant_vld  = 1'b1;
                            end
                            SUB_BFLAGS: begin
                                f_d.bflags     = {view[2], view[1]};
                                f_d.bflags_vld = 1'b1;
                            end
                            SUB_LED: begin
                                f_d.led     = {view[4], view[3], view[2], view[1]};
                                f_d.led_vld = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign fields = f_q;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!f_q.err && !f_q.mac_vld && !f_q.pa_vld && !f_q.country_vld
                   && !f_q.ant_vld && !f_q.bflags_vld && !f_q.led_vld)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.err && !start) |=> f_q.err); // R7
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.country_vld && f_q.pa_vld && !start) |=> (f_q.country_vld && f_q.pa_vld)); // R8
    AST_NO_CHANGE_OFF_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!tup_end && !start) |=> $stable(f_q)); // R1
endmodule

// File: rtl/cis_tuple_parser.sv
module cis_tuple_parser
    import cis_pkg::*;
#(
    parameter int NBYTES = 9,
    parameter int LEN_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        done,
    output logic        err,
    output logic [47:0] mac_addr,
    output logic        mac_vld,
    output logic [15:0] pa_b0,
    output logic [15:0] pa_b1,
    output logic [15:0] pa_b2,
    output logic [7:0]  pa_tssi,
    output logic [7:0]  pa_maxpwr,
    output logic        pa_vld,
    output logic [7:0]  country,
    output logic        country_vld,
    output logic [7:0]  antennas,
    output logic        ant_vld,
    output logic [15:0] board_flags,
    output logic        bflags_vld,
    output logic [31:0] led_info,
    output logic        led_vld
);
    logic                   pl_valid, tup_end;
    logic [LEN_W-1:0]       pl_idx, end_len;
    logic [7:0]             end_type;
    logic [NBYTES-1:0][7:0] view;
    field_set_t             fields;

    cis_tuple_walker #(.LEN_W(LEN_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
        .pl_valid(pl_valid), .pl_idx(pl_idx), .tup_end(tup_end),
        .end_type(end_type), .end_len(end_len), .done(done)
    );

    cis_payload_buf #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_idx(pl_idx),
        .pl_byte(in_byte), .view(view)
    );

    cis_field_regs #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_fields (
        .clk(clk), .rst_n(rst_n), .start(start), .tup_end(tup_end),
        .end_type(end_type), .end_len(end_len), .view(view), .fields(fields)
    );

    assign err         = fields.err;
    assign mac_addr    = fields.mac;
    assign mac_vld     = fields.mac_vld;
    assign pa_b0       = fields.pa_b0;
    assign pa_b1       = fields.pa_b1;
    assign pa_b2       = fields.pa_b2;
    assign pa_tssi     = fields.pa_tssi;
    assign pa_maxpwr   = fields.pa_maxpwr;
    assign pa_vld      = fields.pa_vld;
    assign country     = fields.country;
    assign country_vld = fields.country_vld;
    assign antennas    = fields.antennas;
    assign ant_vld     = fields.ant_vld;
    assign board_flags = fields.bflags;
    assign bflags_vld  = fields.bflags_vld;
    assign led_info    = fields.led;
    assign led_vld     = fields.led_vld;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !start) |=> ($stable(country) && $stable(mac_addr) && $stable(err)
                                   && $stable(done) && $stable(pa_b0))); // R9
    AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(err) && $stable(country_vld) && $stable(ant_vld))); // R2
endmodule

// File: tb/cis_tuple_parser_tb.sv
module cis_tuple_parser_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic done, err, mac_vld, pa_vld, country_vld, ant_vld, bflags_vld, led_vld;
    logic [47:0] mac_addr;
    logic [15:0] pa_b0, pa_b1, pa_b2, board_flags;
    logic [7:0] pa_tssi, pa_maxpwr, country, antennas;
    logic [31:0] led_info;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cis_tuple_parser u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
        .done(done), .err(err), .mac_addr(mac_addr), .mac_vld(mac_vld),
        .pa_b0(pa_b0), .pa_b1(pa_b1), .pa_b2(pa_b2), .pa_tssi(pa_tssi),
        .pa_maxpwr(pa_maxpwr), .pa_vld(pa_vld), .country(country),
        .country_vld(country_vld), .antennas(antennas), .ant_vld(ant_vld),
        .board_flags(board_flags), .bflags_vld(bflags_vld), .led_info(led_info),
        .led_vld(led_vld)
    );

    // fld: 0 mac, 1 pa {b0,b1,b2,tssi,maxpwr}, 2 country, 3 antennas, 4 board flags, 5 led
    typedef struct packed {
        logic [3:0]  n;
        logic [95:0] bytes;
        logic [2:0]  fld;
        logic [63:0] val;
        logic        vld;
        logic        err;
        logic        done;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  96'h8002053C_00000000_00000000, 3'd2, 64'h3C, 1'b1, 1'b0, 1'b0},                 // R5 country
        '{4'd4,  96'h80020605_00000000_00000000, 3'd3, 64'h05, 1'b1, 1'b0, 1'b0},                 // R5 antennas
        '{4'd5,  96'h80030834_12000000_00000000, 3'd4, 64'h1234, 1'b1, 1'b0, 1'b0},               // R6 flags
        '{4'd7,  96'h80050911_22334400_00000000, 3'd5, 64'h44332211, 1'b1, 1'b0, 1'b0},           // R6 led
        '{4'd11, 96'h80090301_02030405_06070800, 3'd1, 64'h0201_0403_0605_0708, 1'b1, 1'b0, 1'b0},// R4 pa
        '{4'd10, 96'h22080406_00112233_44550000, 3'd0, 64'h0011_2233_4455, 1'b1, 1'b0, 1'b0},     // R3 mac
        '{4'd8,  96'h1502AABB_8002057E_00000000, 3'd2, 64'h7E, 1'b1, 1'b0, 1'b0},                 // R1 skip
        '{4'd5,  96'h80030501_02000000_00000000, 3'd2, 64'h00, 1'b0, 1'b1, 1'b0},                 // R7 size
        '{4'd6,  96'h10008002_060F0000_00000000, 3'd3, 64'h0F, 1'b1, 1'b0, 1'b0},                 // R1 zero len
        '{4'd5,  96'hFF800205_99000000_00000000, 3'd2, 64'h00, 1'b0, 1'b0, 1'b1},                 // R2 term
        '{4'd10, 96'h22080405_00112233_44550000, 3'd0, 64'h00, 1'b0, 1'b1, 1'b0},                 // R3 bad node
        '{4'd9,  96'h80030201_00800205_22000000, 3'd2, 64'h22, 1'b1, 1'b0, 1'b0}                  // R7 ignored sub
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:    return "R5";
            2, 3:    return "R6";
            4:       return "R4";
            5, 10:   return "R3";
            6, 8:    return "R1";
            7, 11:   return "R7";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [63:0] sel_val(logic [2:0] f);
        case (f)
            3'd0:    return {16'h0, mac_addr};
            3'd1:    return {pa_b0, pa_b1, pa_b2, pa_tssi, pa_maxpwr};
            3'd2:    return {56'h0, country};
            3'd3:    return {56'h0, antennas};
            3'd4:    return {48'h0, board_flags};
            default: return {32'h0, led_info};
        endcase
    endfunction

    function automatic logic sel_vld(logic [2:0] f);
        case (f)
            3'd0:    return mac_vld;
            3'd1:    return pa_vld;
            3'd2:    return country_vld;
            3'd3:    return ant_vld;
            3'd4:    return bflags_vld;
            default: return led_vld;
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_byte = b;
    endtask

    task automatic idle();
        @(negedge clk); in_valid = 1'b0; in_byte = 8'hFF;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 done", {63'h0, done}, 64'h0);
        chk("R10 err", {63'h0, err}, 64'h0);
        chk("R10 valids", {58'h0, mac_vld, pa_vld, country_vld, ant_vld, bflags_vld, led_vld}, 64'h0);
        chk("R10 fields", {country, antennas, board_flags, 32'h0} | {32'h0, led_info}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pulse_start();
            for (int k = 0; k < int'(VECS[i].n); k++) send(VECS[i].bytes[95 - 8*k -: 8]);
            idle();
            chk($sformatf("%s vec%0d value", vec_tag(i), i), sel_val(VECS[i].fld), VECS[i].val);
            chk($sformatf("%s vec%0d valid", vec_tag(i), i), {63'h0, sel_vld(VECS[i].fld)}, {63'h0, VECS[i].vld});
            chk($sformatf("%s vec%0d err", vec_tag(i), i), {63'h0, err}, {63'h0, VECS[i].err});
            chk($sformatf("%s vec%0d done", vec_tag(i), i), {63'h0, done}, {63'h0, VECS[i].done});
        end

        // R7: bad-size subelement keeps the earlier good value
        pulse_start();
        send(8'h80); send(8'h02); send(8'h05); send(8'h3C);
        send(8'h80); send(8'h03); send(8'h05); send(8'hAA); send(8'hBB);
        idle();
        chk("R7 keep value", {56'h0, country}, 64'h3C);
        chk("R7 keep valid", {63'h0, country_vld}, 64'h1);
        chk("R7 err set", {63'h0, err}, 64'h1);

        // R8: start clears
        pulse_start();
        chk("R8 err cleared", {63'h0, err}, 64'h0);
        chk("R8 valid cleared", {56'h0, country}, 64'h0);

        // R9: idle cycles carrying 0xFF are ignored
        idle(); send(8'h80); idle(); send(8'h02); idle(); send(8'h05); idle(); send(8'h5A);
        idle(); idle();
        chk("R9 country", {56'h0, country}, 64'h5A);
        chk("R9 not done", {63'h0, done}, 64'h0);

        // R2: after terminator input ignored until start
        pulse_start();
        send(8'hFF); send(8'h80); send(8'h02); send(8'h06); send(8'h03);
        idle();
        chk("R2 ant ignored", {63'h0, ant_vld}, 64'h0);
        chk("R2 done", {63'h0, done}, 64'h1);
        pulse_start();
        chk("R8 done cleared", {63'h0, done}, 64'h0);
        send(8'h80); send(8'h02); send(8'h06); send(8'h03);
        idle();
        chk("R2 restart ant", {56'h0, antennas}, 64'h03);

        // R8: start in the middle of a tuple drops it; byte with start dropped
        pulse_start();
        send(8'h80); send(8'h09); send(8'h03); send(8'h01); send(8'h02);
        @(negedge clk); start = 1'b1; in_valid = 1'b1; in_byte = 8'h80;
        @(negedge clk); start = 1'b0;
        in_byte = 8'h80;
        send(8'h02); send(8'h05); send(8'h44);
        idle();
        chk("R8 restart country", {56'h0, country}, 64'h44);
        chk("R8 restart pa", {63'h0, pa_vld}, 64'h0);
        chk("R8 restart err", {63'h0, err}, 64'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule